// File: doc/BRIEF.md
# L0s Transmit Standby Controller

This block decides, cycle by cycle, whether one link transmitter may drop into the L0s standby state, and runs the ordered-set sequence that takes it there and brings it back. The decision that the link is quiet depends on the kind of port the block serves. An endpoint or a root port only looks at its own pending traffic. A switch port must also see its peer receive lanes already in standby. Entry is permitted only while hardware-managed standby is enabled and the function is in D0.

Entry sends one EIOS, then goes silent, and raises the electrical-idle output to the analog front end after a fixed, parameterised number of cycles. Once idle, the transmitter stays quiet for a minimum number of cycles. When traffic reappears, the block leaves standby on its own after that minimum. At the base rate it sends FTS ordered sets straight away. At faster rates it sends one EIEOS before them. The FTS count equals the value negotiated during training. The downstream framer confirms each requested ordered set with a one-cycle acknowledge. Nanosecond limits are expressed as cycle-count parameters.

Top module: `l0s_tx_ctrl`

## Requirements
- R1: While reset is held, and on its release, `lpState` reads 0 (L0), `elecIdle` is low and `osType` is 0 (data).
- R2: With `portKind`=0 (endpoint/root), the link is quiet when `dllpPending` is low and either `tlpPending` is low or `fcBlocked` is high. If it is quiet in an L0 cycle, the next cycle shows `lpState`=1 (entry) and `osType`=1 (EIOS).
- R3: With `portKind`=1 (upstream switch port), quiet additionally needs every bit of `dsRxL0s` set.
- R4: With `portKind`=2 (downstream switch port), quiet additionally needs `usRxL0s`. With `portKind`=3, entry never starts.
- R5: Entry starts only while both `aspmL0sEn` and `inD0` are high.
- R6: `osType` stays 1 (EIOS) until `osAck` is seen, then reads 4 (none). `elecIdle` rises exactly EIOS_IDLE_CYC cycles after the acknowledged cycle, and `osType` stays 4 for the whole time `elecIdle` is high.
- R7: `elecIdle` stays high for at least MIN_IDLE_CYC cycles. A wake request that arrives in the first standby cycle gives exactly MIN_IDLE_CYC cycles.
- R8: In standby, once the link is no longer quiet and the minimum has passed, `elecIdle` falls on the next edge and `lpState` reads 3 (exit).
- R9: With `linkSpeed`=0 (2.5 GT/s), exit sends FTS (`osType`=3) directly. With any other `linkSpeed`, exactly one EIEOS (`osType`=2) precedes the first FTS.
- R10: Exit sends exactly `nFts` acknowledged FTS sets, latched at exit start, and `lpState` returns to 0 on the edge that takes the last acknowledge. When `nFts` is 0, no FTS is sent.
- R11: `lpState` is 2 exactly while `elecIdle` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| aspmL0sEn | input | 1 | Hardware standby enable |
| inD0 | input | 1 | Function is in D0 |
| tlpPending | input | 1 | Transaction packets waiting |
| fcBlocked | input | 1 | Waiting packets held only by missing credit |
| dllpPending | input | 1 | Link-layer packets waiting |
| portKind | input | 2 | 0 endpoint/root, 1 upstream switch, 2 downstream switch, 3 reserved |
| dsRxL0s | input | NUM_DS | Downstream ports' receive lanes in standby |
| usRxL0s | input | 1 | Upstream port's receive lanes in standby |
| linkSpeed | input | 2 | 0 = 2.5 GT/s, other = faster |
| nFts | input | NFTS_W | Trained FTS count |
| osAck | input | 1 | Requested ordered set completed this cycle |
| osType | output | 3 | 0 data, 1 EIOS, 2 EIEOS, 3 FTS, 4 none |
| elecIdle | output | 1 | Electrical idle to the analog front end |
| lpState | output | 2 | 0 L0, 1 entry, 2 standby, 3 exit |

## Verification
The quiet-link decision is swept over every combination of port kind, traffic flags, enable, D0 and peer lane status. Each is checked against an arithmetic model, which separates the per-kind conditions from one another and from the shared traffic and enable terms. Full entry and exit cycles are run over speeds and FTS counts of 0, 1 and 3. Each is run once with a wake in the first standby cycle and once with a late wake. This separates the minimum-hold timing from the normal exit, and the EIEOS preamble from the base-rate path.

// File: rtl/l0s_pkg.sv
package l0s_pkg;
  typedef enum logic [1:0] {
    LP_L0    = 2'd0,
    LP_ENTRY = 2'd1,
    LP_STBY  = 2'd2,
    LP_EXIT  = 2'd3
  } lpState_e;

  typedef enum logic [2:0] {
    OS_DATA  = 3'd0,
    OS_EIOS  = 3'd1,
    OS_EIEOS = 3'd2,
    OS_FTS   = 3'd3,
    OS_NONE  = 3'd4
  } osKind_e;

  typedef enum logic [1:0] {
    PK_ENDPT = 2'd0,
    PK_SWUP  = 2'd1,
    PK_SWDN  = 2'd2,
    PK_RSVD  = 2'd3
  } portKind_e;

  typedef struct packed {
    logic tmrClr;
    logic seqStart;
    logic seqAck;
  } dpStrobe_t;
endpackage

// File: rtl/l0s_idle_detect.sv
module l0s_idle_detect
  import l0s_pkg::*;
#(
  parameter int NUM_DS = 4
) (
  input  logic              aspmL0sEn,
  input  logic              inD0,
  input  logic              tlpPending,
  input  logic              fcBlocked,
  input  logic              dllpPending,
  input  logic [1:0]        portKind,
  input  logic [NUM_DS-1:0] dsRxL0s,
  input  logic              usRxL0s,
  output logic              linkQuiet
);
  logic ownQuiet;
  logic allDsStby;
  logic peerOk;

  generate
    if (NUM_DS > 0) begin : g_ds
      assign allDsStby = &dsRxL0s;
    end else begin : g_nods
      assign allDsStby = 1'b1;
    end
  endgenerate

  assign ownQuiet = !dllpPending && (!tlpPending || fcBlocked);

  always_comb begin
    unique case (portKind_e'(portKind))
      PK_ENDPT: peerOk = 1'b1;
      PK_SWUP:  peerOk = allDsStby;
      PK_SWDN:  peerOk = usRxL0s;
      default:  peerOk = 1'b0;
    endcase
  end

  assign linkQuiet = aspmL0sEn && inD0 && ownQuiet && peerOk;
endmodule

// File: rtl/l0s_tx_datapath.sv
module l0s_tx_datapath
  import l0s_pkg::*;
#(
  parameter int EIOS_IDLE_CYC = 2,
  parameter int MIN_IDLE_CYC  = 5,
  parameter int NFTS_W        = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         stb,
  input  logic [NFTS_W-1:0] nFts,
  input  logic              fastLink,
  output logic              eiosDue,
  output logic              minMet,
  output logic              eieosPend,
  output logic              seqLast,
  output logic              seqEmpty
);
  localparam int TMR_MAX = (EIOS_IDLE_CYC > MIN_IDLE_CYC) ? EIOS_IDLE_CYC : MIN_IDLE_CYC;
  localparam int TMR_W   = $clog2(TMR_MAX + 1);

  logic [TMR_W-1:0]  tmr;
  logic [NFTS_W-1:0] nLat;
  logic [NFTS_W-1:0] ftsCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tmr <= '0;
    end else if (stb.tmrClr) begin
      tmr <= '0;
    end else if (tmr != TMR_W'(TMR_MAX)) begin
      tmr <= tmr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      nLat      <= '0;
      ftsCnt    <= '0;
      eieosPend <= 1'b0;
    end else if (stb.seqStart) begin
      nLat      <= nFts;
      ftsCnt    <= '0;
      eieosPend <= fastLink;
    end else if (stb.seqAck) begin
      if (eieosPend) eieosPend <= 1'b0;
      else           ftsCnt    <= ftsCnt + 1'b1;
    end
  end

  assign eiosDue  = (tmr == TMR_W'(EIOS_IDLE_CYC - 1));
  assign minMet   = (tmr >= TMR_W'(MIN_IDLE_CYC - 1));
  assign seqEmpty = !eieosPend && (ftsCnt == nLat);
  assign seqLast  = eieosPend ? (nLat == '0) : (NFTS_W'(ftsCnt + 1'b1) == nLat);
endmodule

// File: rtl/l0s_tx_fsm.sv
module l0s_tx_fsm
  import l0s_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      linkQuiet,
  input  logic      osAck,
  input  logic      eiosDue,
  input  logic      minMet,
  input  logic      eieosPend,
  input  logic      seqLast,
  input  logic      seqEmpty,
  output dpStrobe_t stb,
  output osKind_e   osKind,
  output lpState_e  curState
);
  lpState_e nextState;
  logic     eiosSent;
  logic     eiosSentNext;

  always_comb begin
    nextState    = curState;
    eiosSentNext = eiosSent;
    stb          = '0;
    osKind       = OS_NONE;
    unique case (curState)
      LP_L0: begin
        osKind = OS_DATA;
        if (linkQuiet) begin
          nextState    = LP_ENTRY;
          eiosSentNext = 1'b0;
        end
      end
      LP_ENTRY: begin
        if (!eiosSent) begin
          osKind = OS_EIOS;
          if (osAck) begin
            eiosSentNext = 1'b1;
            stb.tmrClr   = 1'b1;
          end
        end else if (eiosDue) begin
          nextState  = LP_STBY;
          stb.tmrClr = 1'b1;
        end
      end
      LP_STBY: begin
        if (!linkQuiet && minMet) begin
          nextState    = LP_EXIT;
          stb.seqStart = 1'b1;
        end
      end
      default: begin
        if (seqEmpty) begin
          nextState = LP_L0;
        end else begin
          osKind = eieosPend ? OS_EIEOS : OS_FTS;
          if (osAck) begin
            stb.seqAck = 1'b1;
            if (seqLast) nextState = LP_L0;
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curState <= LP_L0;
      eiosSent <= 1'b0;
    end else begin
      curState <= nextState;
      eiosSent <= eiosSentNext;
    end
  end
endmodule

// File: rtl/l0s_tx_ctrl.sv
module l0s_tx_ctrl
  import l0s_pkg::*;
#(
  parameter int EIOS_IDLE_CYC = 2,
  parameter int MIN_IDLE_CYC  = 5,
  parameter int NUM_DS        = 4,
  parameter int NFTS_W        = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              aspmL0sEn,
  input  logic              inD0,
  input  logic              tlpPending,
  input  logic              fcBlocked,
  input  logic              dllpPending,
  input  logic [1:0]        portKind,
  input  logic [NUM_DS-1:0] dsRxL0s,
  input  logic              usRxL0s,
  input  logic [1:0]        linkSpeed,
  input  logic [NFTS_W-1:0] nFts,
  input  logic              osAck,
  output logic [2:0]        osType,
  output logic              elecIdle,
  output logic [1:0]        lpState
);
  logic      linkQuiet;
  logic      eiosDue, minMet, eieosPend, seqLast, seqEmpty;
  dpStrobe_t stb;
  osKind_e   osKind;
  lpState_e  curState;

  l0s_idle_detect #(.NUM_DS(NUM_DS)) u_idle (
    .aspmL0sEn(aspmL0sEn), .inD0(inD0), .tlpPending(tlpPending),
    .fcBlocked(fcBlocked), .dllpPending(dllpPending), .portKind(portKind),
    .dsRxL0s(dsRxL0s), .usRxL0s(usRxL0s), .linkQuiet(linkQuiet)
  );

  l0s_tx_fsm u_fsm (
    .clk(clk), .rstN(rstN), .linkQuiet(linkQuiet), .osAck(osAck),
    .eiosDue(eiosDue), .minMet(minMet), .eieosPend(eieosPend),
    .seqLast(seqLast), .seqEmpty(seqEmpty), .stb(stb),
    .osKind(osKind), .curState(curState)
  );

  l0s_tx_datapath #(
    .EIOS_IDLE_CYC(EIOS_IDLE_CYC), .MIN_IDLE_CYC(MIN_IDLE_CYC), .NFTS_W(NFTS_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .nFts(nFts),
    .fastLink(linkSpeed != 2'd0), .eiosDue(eiosDue), .minMet(minMet),
    .eieosPend(eieosPend), .seqLast(seqLast), .seqEmpty(seqEmpty)
  );

  assign osType   = osKind;
  assign lpState  = curState;
  assign elecIdle = (curState == LP_STBY);
endmodule

// File: rtl/l0s_tx_chk.sv
module l0s_tx_chk #(
  parameter int EIOS_IDLE_CYC = 2,
  parameter int MIN_IDLE_CYC  = 5
) (
  input logic       clk,
  input logic       rstN,
  input logic       aspmL0sEn,
  input logic       inD0,
  input logic [1:0] linkSpeed,
  input logic       osAck,
  input logic [2:0] osType,
  input logic       elecIdle,
  input logic [1:0] lpState
);
  logic [7:0] sinceAck;
  logic [7:0] idleRun;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sinceAck <= 8'hff;
      idleRun  <= '0;
    end else begin
      if (osType == 3'd1 && osAck) sinceAck <= '0;
      else if (sinceAck != 8'hff)  sinceAck <= sinceAck + 1'b1;
      if (elecIdle) idleRun <= (idleRun == 8'hff) ? idleRun : idleRun + 1'b1;
      else          idleRun <= '0;
    end
  end

  // R6
  eios_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(elecIdle) |-> sinceAck == 8'(EIOS_IDLE_CYC));

  // R6
  quiet_tx_chk: assert property (@(posedge clk) disable iff (!rstN)
    elecIdle |-> osType == 3'd4);

  // R7
  min_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(elecIdle) |-> idleRun >= 8'(MIN_IDLE_CYC));

  // R9
  eieos_speed_chk: assert property (@(posedge clk) disable iff (!rstN)
    osType == 3'd2 |-> (linkSpeed != 2'd0 && lpState == 2'd3));

  // R5
  entry_enable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (lpState == 2'd1 && $past(lpState) == 2'd0) |-> $past(aspmL0sEn && inD0));

  // R11
  status_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (lpState == 2'd2) == elecIdle);
endmodule

bind l0s_tx_ctrl l0s_tx_chk #(
  .EIOS_IDLE_CYC(EIOS_IDLE_CYC), .MIN_IDLE_CYC(MIN_IDLE_CYC)
) u_chk (
  .clk(clk), .rstN(rstN), .aspmL0sEn(aspmL0sEn), .inD0(inD0),
  .linkSpeed(linkSpeed), .osAck(osAck), .osType(osType),
  .elecIdle(elecIdle), .lpState(lpState)
);

// File: tb/sim_l0s_tx_ctrl.sv
module sim_l0s_tx_ctrl;
  localparam int D   = 2;
  localparam int MIN = 5;
  localparam int NDS = 2;
  localparam int NW  = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic aspmL0sEn = 0, inD0 = 0, tlpPending = 0, fcBlocked = 0, dllpPending = 0;
  logic [1:0] portKind = 0;
  logic [NDS-1:0] dsRxL0s = 0;
  logic usRxL0s = 0;
  logic [1:0] linkSpeed = 0;
  logic [NW-1:0] nFts = 0;
  logic osAck = 0;
  logic [2:0] osType;
  logic elecIdle;
  logic [1:0] lpState;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  l0s_tx_ctrl #(.EIOS_IDLE_CYC(D), .MIN_IDLE_CYC(MIN), .NUM_DS(NDS), .NFTS_W(NW)) u0 (
    .clk(clk), .rstN(rstN), .aspmL0sEn(aspmL0sEn), .inD0(inD0),
    .tlpPending(tlpPending), .fcBlocked(fcBlocked), .dllpPending(dllpPending),
    .portKind(portKind), .dsRxL0s(dsRxL0s), .usRxL0s(usRxL0s),
    .linkSpeed(linkSpeed), .nFts(nFts), .osAck(osAck),
    .osType(osType), .elecIdle(elecIdle), .lpState(lpState)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    cyc();
    rstN = 1'b1;
  endtask

  // full entry/exit cycle from an idle endpoint
  task automatic runCycle(input int spd, input int nf, input bit early);
    int n, hi, idx, eie, fts, guard;
    bit orderOk;
    aspmL0sEn = 1; inD0 = 1; tlpPending = 0; fcBlocked = 0; dllpPending = 0;
    portKind = 0; linkSpeed = 2'(spd); nFts = NW'(nf); osAck = 0;
    doReset();
    cyc();
    check(lpState == 2'd1 && osType == 3'd1, "R2 entry/EIOS", int'(osType), 1);
    cyc(); cyc();
    check(osType == 3'd1 && !elecIdle, "R6 EIOS held without ack", int'(osType), 1);
    osAck = 1;
    cyc();
    osAck = 0;
    check(osType == 3'd4, "R6 silent after EIOS", int'(osType), 4);
    n = 0;
    while (!elecIdle && n < 20) begin
      cyc();
      n++;
    end
    check(n == D, "R6 EIOS-to-idle cycles", n, D);
    check(lpState == 2'd2, "R11 standby status", int'(lpState), 2);
    hi = 1; idx = 0;
    forever begin
      if ((early && idx == 0) || (!early && idx == MIN + 2)) tlpPending = 1;
      cyc();
      idx++;
      if (elecIdle) begin
        hi++;
        if (osType != 3'd4) check(0, "R6 silent in idle", int'(osType), 4);
      end else break;
      if (idx > 40) break;
    end
    if (early) check(hi == MIN, "R7 early wake idle length", hi, MIN);
    else       check(hi == MIN + 3, "R8 late wake idle length", hi, MIN + 3);
    check(lpState == 2'd3, "R8 exit status", int'(lpState), 3);
    eie = 0; fts = 0; orderOk = 1; guard = 0;
    while (lpState == 2'd3 && guard < 64) begin
      if (osType == 3'd2) begin
        if (fts > 0) orderOk = 0;
        eie++;
      end else if (osType == 3'd3) fts++;
      osAck = 1;
      cyc();
      osAck = 0;
      guard++;
    end
    check(eie == ((spd != 0) ? 1 : 0), "R9 EIEOS count", eie, (spd != 0) ? 1 : 0);
    check(orderOk, "R9 EIEOS before FTS", int'(orderOk), 1);
    check(fts == nf, "R10 FTS count", fts, nf);
    check(lpState == 2'd0 && osType == 3'd0, "R10 back in L0", int'(lpState), 0);
    tlpPending = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog (all requirements): actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    rstN = 0;
    cyc();
    check(lpState == 2'd0 && !elecIdle && osType == 3'd0, "R1 reset state", int'(lpState), 0);
    rstN = 1;
    cyc();
    check(lpState == 2'd0 && !elecIdle && osType == 3'd0, "R1 after release", int'(lpState), 0);

    // R2 R3 R4 R5 sweep of the quiet-link decision
    for (int pk = 0; pk < 4; pk++)
      for (int v = 0; v < 32; v++)
        for (int ds = 0; ds < (1 << NDS); ds++)
          for (int us = 0; us < 2; us++) begin
            bit exp, peer;
            @(negedge clk);
            rstN = 0;
            portKind = 2'(pk);
            tlpPending = v[0]; fcBlocked = v[1]; dllpPending = v[2];
            aspmL0sEn = v[3]; inD0 = v[4];
            dsRxL0s = NDS'(ds); usRxL0s = us[0]; osAck = 0;
            cyc();
            rstN = 1;
            cyc();
            peer = (pk == 0) ? 1'b1 : (pk == 1) ? (ds == (1 << NDS) - 1) : (pk == 2) ? us[0] : 1'b0;
            exp = v[3] && v[4] && !v[2] && (!v[0] || v[1]) && peer;
            check((lpState == 2'd1) == exp,
                  (pk == 0) ? "R2 endpoint quiet" : (pk == 1) ? "R3 upstream switch quiet" :
                  (pk == 2) ? "R4 downstream switch quiet" : "R4 reserved kind / R5 enable",
                  int'(lpState), exp ? 1 : 0);
          end

    for (int spd = 0; spd < 3; spd++)
      for (int k = 0; k < 3; k++)
        for (int e = 0; e < 2; e++)
          runCycle(spd, (k == 0) ? 0 : (k == 1) ? 1 : 3, e[0]);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule